// File: doc/BRIEF.md
# Two-Wire Register-Bank Slave with 7+9 Word Packing

This block is the serial control port of a bank of 128 nine-bit configuration registers. A host reaches it over a standard I2C bus. The block oversamples the SCL and SDA lines with the system clock and recognises START, repeated START and STOP. It answers on a 7-bit device address whose least significant bit comes from a board strap pin.

Each register access moves a 16-bit control word, sent MSB first. The upper seven bits name the register and the lower nine bits are its value. The value's top bit therefore travels in the same byte as the register number, and the second byte carries the remaining eight bits. A write stores the word only once the whole word has been acknowledged. A read sets the register pointer with a write-direction phase, then follows with a repeated START and the read-direction address. After that the slave returns the same two-byte layout for as long as the master keeps acknowledging.

The slave never drives SDA high. Its output `sda_oe` requests a pull-down, and the pad turns it into an open-drain driver.

Top module: `i2c_regbank_slave`

## Requirements
- R1: SCL and SDA pass through a two-flop synchroniser. A falling SDA while SCL is high is a START, and a rising SDA while SCL is high is a STOP. A START in any state, including one in the middle of a transfer (a repeated START), restarts the device-address phase.
- R2: The device address is 7'b0011010 with the strap at 0 and 7'b0011011 with the strap at 1 (R/W is the eighth bit, 1 = read). On a match the slave pulls SDA low for the ninth clock. On a mismatch it never pulls SDA and ignores the bus until the next START or STOP.
- R3: In a write, the byte after the device address carries the register number in bits 7..1 and data bit 8 in bit 0. The next byte carries data bits 7..0. The slave acknowledges both bytes.
- R4: The register is updated only at the end of the acknowledge of the second data-carrying byte. A STOP or START arriving earlier discards the partial word and leaves the register unchanged.
- R5: Any byte after a completed write word is neither acknowledged nor stored.
- R6: In a read, the slave sends first {register number, data bit 8}, then data bits 7..0, each MSB first. While the master acknowledges, it keeps alternating between these two bytes.
- R7: A master no-acknowledge after a sent byte makes the slave release SDA and stay silent until the next START or STOP.
- R8: The slave changes `sda_oe` only while SCL is low, apart from the forced release on START/STOP, and it only ever pulls the line low.
- R9: After reset, every register reads 0 and SDA is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_strap | input | 1 | Selects the device address LSB |
| scl_i | input | 1 | SCL line as seen at the pad |
| sda_i | input | 1 | SDA line as seen at the pad (wired-AND with the slave pull-down) |
| sda_oe | output | 1 | 1 = pull SDA low, 0 = release |

## Verification
The hardest situation to reach from the ports is a control word cut short: a STOP a few bits into the data byte, or a repeated START right after the register byte. Both must leave the register untouched, and the next word must still land correctly. The bench drives the bus bit by bit through a master task that can stop after any number of bits and insert START or STOP at will. It then reads the affected registers back over the same bus. The master-acknowledge path gets the same treatment: multi-byte reads that acknowledge several bytes and then NACK, followed by extra clocks that must return all ones.

// File: rtl/i2c_rb_pkg.sv
package i2c_rb_pkg;

  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_REG,
    ST_DATA,
    ST_SACK,
    ST_TX,
    ST_MACK,
    ST_IGNORE
  } fsm_st_e;

  typedef enum logic [1:0] {
    PH_ADDRW,
    PH_RD,
    PH_REG,
    PH_DATA
  } ack_ph_e;

endpackage

// File: rtl/i2c_rb_sync.sv
module i2c_rb_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);

  logic [STAGES-1:0] scl_ff;
  logic [STAGES-1:0] sda_ff;
  logic              scl_q;
  logic              sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[STAGES-2:0], scl_i};
      sda_ff <= {sda_ff[STAGES-2:0], sda_i};
      scl_q  <= scl_ff[STAGES-1];
      sda_q  <= sda_ff[STAGES-1];
    end
  end

  assign scl_s     = scl_ff[STAGES-1];
  assign sda_s     = sda_ff[STAGES-1];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  // SDA edges while SCL held high on both samples
  assign start_evt = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_evt  = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/i2c_rb_regfile.sv
module i2c_rb_regfile #(
  parameter int AW = 7,
  parameter int DW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (wr_en) begin
      mem[wr_addr] <= wr_data;
    end
  end

  assign rd_data = mem[rd_addr];

endmodule

// File: rtl/i2c_rb_fsm.sv
module i2c_rb_fsm
  import i2c_rb_pkg::*;
#(
  parameter int                 REG_AW   = 7,
  parameter int                 REG_DW   = 9,
  parameter int                 DEV_W    = 7,
  parameter logic [DEV_W-2:0]   DEV_BASE = 6'b001101
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strap,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_evt,
  input  logic              stop_evt,
  input  logic [REG_DW-1:0] rd_data,
  output logic [REG_AW-1:0] reg_ptr,
  output logic              wr_en,
  output logic [REG_DW-1:0] wr_data,
  output logic              sda_oe,
  output fsm_st_e           state
);

  localparam int HI_W  = REG_DW - BYTE_W;
  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] BITS_FULL = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] BITS_LAST = CNT_W'(BYTE_W - 1);

  // address byte bits 7..1 against the strap-completed device address
  function automatic logic addr_hit(input logic [BYTE_W-1:0] b, input logic s);
    return b[BYTE_W-1:1] == {DEV_BASE, s};
  endfunction

  // first byte returned on a read: register number and data high bits
  function automatic logic [BYTE_W-1:0] tx_first(input logic [REG_AW-1:0] p,
                                                  input logic [REG_DW-1:0] d);
    return {p, d[REG_DW-1:BYTE_W]};
  endfunction

  function automatic logic [BYTE_W-1:0] tx_second(input logic [REG_DW-1:0] d);
    return d[BYTE_W-1:0];
  endfunction

  fsm_st_e           st;
  ack_ph_e           ack_of;
  logic [CNT_W-1:0]  bitcnt;
  logic [BYTE_W-1:0] shreg;
  logic [BYTE_W-1:0] txsh;
  logic [HI_W-1:0]   dhi;
  logic              tx_sel;
  logic              m_nak;
  logic [BYTE_W-1:0] tx_next;

  assign tx_next = tx_sel ? tx_second(rd_data) : tx_first(reg_ptr, rd_data);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      ack_of  <= PH_ADDRW;
      bitcnt  <= '0;
      shreg   <= '0;
      txsh    <= '0;
      reg_ptr <= '0;
      dhi     <= '0;
      tx_sel  <= 1'b0;
      m_nak   <= 1'b0;
      sda_oe  <= 1'b0;
    end else if (start_evt) begin
      st     <= ST_ADDR;
      bitcnt <= '0;
      sda_oe <= 1'b0;
    end else if (stop_evt) begin
      st     <= ST_IDLE;
      sda_oe <= 1'b0;
    end else begin
      case (st)
        ST_ADDR, ST_REG, ST_DATA: begin
          if (scl_rise && bitcnt != BITS_FULL) begin
            shreg  <= {shreg[BYTE_W-2:0], sda_s};
            bitcnt <= bitcnt + 1'b1;
          end else if (scl_fall && bitcnt == BITS_FULL) begin
            bitcnt <= '0;
            case (st)
              ST_ADDR: begin
                if (addr_hit(shreg, strap)) begin
                  sda_oe <= 1'b1;
                  st     <= ST_SACK;
                  ack_of <= shreg[0] ? PH_RD : PH_ADDRW;
                end else begin
                  st <= ST_IGNORE;
                end
              end
              ST_REG: begin
                {reg_ptr, dhi} <= shreg;
                sda_oe         <= 1'b1;
                st             <= ST_SACK;
                ack_of         <= PH_REG;
              end
              default: begin
                sda_oe <= 1'b1;
                st     <= ST_SACK;
                ack_of <= PH_DATA;
              end
            endcase
          end
        end
        ST_SACK: begin
          if (scl_fall) begin
            bitcnt <= '0;
            case (ack_of)
              PH_ADDRW: begin sda_oe <= 1'b0; st <= ST_REG;    end
              PH_REG:   begin sda_oe <= 1'b0; st <= ST_DATA;   end
              PH_DATA:  begin sda_oe <= 1'b0; st <= ST_IGNORE; end
              default: begin
                txsh   <= tx_first(reg_ptr, rd_data);
                sda_oe <= ~tx_first(reg_ptr, rd_data)[BYTE_W-1];
                tx_sel <= 1'b1;
                st     <= ST_TX;
              end
            endcase
          end
        end
        ST_TX: begin
          if (scl_fall) begin
            if (bitcnt == BITS_LAST) begin
              sda_oe <= 1'b0;
              bitcnt <= '0;
              st     <= ST_MACK;
            end else begin
              bitcnt <= bitcnt + 1'b1;
              txsh   <= {txsh[BYTE_W-2:0], 1'b0};
              sda_oe <= ~txsh[BYTE_W-2];
            end
          end
        end
        ST_MACK: begin
          if (scl_rise) begin
            m_nak <= sda_s;
          end else if (scl_fall) begin
            if (m_nak) begin
              st <= ST_IGNORE;
            end else begin
              txsh   <= tx_next;
              sda_oe <= ~tx_next[BYTE_W-1];
              tx_sel <= ~tx_sel;
              st     <= ST_TX;
            end
          end
        end
        default: ;
      endcase
    end
  end

  // commit only on the SCL fall that closes the ack of the last byte
  assign wr_en   = (st == ST_SACK) && (ack_of == PH_DATA) && scl_fall
                   && !start_evt && !stop_evt;
  assign wr_data = {dhi, shreg};
  assign state   = st;

endmodule

// File: rtl/i2c_regbank_slave.sv
module i2c_regbank_slave
  import i2c_rb_pkg::*;
#(
  parameter int               REG_AW      = 7,
  parameter int               REG_DW      = 9,
  parameter int               SYNC_STAGES = 2,
  parameter int               DEV_W       = 7,
  parameter logic [DEV_W-2:0] DEV_BASE    = 6'b001101
) (
  input  logic clk,
  input  logic rst_n,
  input  logic addr_strap,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe
);

  logic              scl_s;
  logic              sda_s;
  logic              scl_rise;
  logic              scl_fall;
  logic              start_evt;
  logic              stop_evt;
  logic              wr_en;
  logic [REG_AW-1:0] reg_ptr;
  logic [REG_DW-1:0] wr_data;
  logic [REG_DW-1:0] rd_data;
  fsm_st_e           fsm_state;

  i2c_rb_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_evt (start_evt),
    .stop_evt  (stop_evt)
  );

  i2c_rb_fsm #(
    .REG_AW   (REG_AW),
    .REG_DW   (REG_DW),
    .DEV_W    (DEV_W),
    .DEV_BASE (DEV_BASE)
  ) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .strap     (addr_strap),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_evt (start_evt),
    .stop_evt  (stop_evt),
    .rd_data   (rd_data),
    .reg_ptr   (reg_ptr),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .sda_oe    (sda_oe),
    .state     (fsm_state)
  );

  i2c_rb_regfile #(.AW(REG_AW), .DW(REG_DW)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (reg_ptr),
    .wr_data (wr_data),
    .rd_addr (reg_ptr),
    .rd_data (rd_data)
  );

endmodule

// File: rtl/i2c_rb_checker.sv
module i2c_rb_checker
  import i2c_rb_pkg::*;
(
  input logic    clk,
  input logic    rst_n,
  input logic    scl_s,
  input logic    scl_fall,
  input logic    start_evt,
  input logic    stop_evt,
  input logic    wr_en,
  input logic    sda_oe,
  input fsm_st_e fsm_state
);

  // R1: a START always reopens the device-address phase
  a_r1_start_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> fsm_state == ST_ADDR);

  // R1: a STOP returns the slave to idle
  a_r1_stop_idles: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_evt && !start_evt) |=> fsm_state == ST_IDLE);

  // R2, R7: an ignoring slave keeps SDA released
  a_r2_ignore_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (fsm_state == ST_IGNORE && $past(fsm_state) == ST_IGNORE) |-> !sda_oe);

  // R4: register commit lands on an SCL falling edge
  a_r4_commit_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (scl_fall && !scl_s));

  // R8: output enable moves only in the SCL low phase
  a_r8_oe_low_phase: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(start_evt || stop_evt) && sda_oe != $past(sda_oe)) |-> !$past(scl_s));

endmodule

bind i2c_regbank_slave i2c_rb_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .scl_s     (scl_s),
  .scl_fall  (scl_fall),
  .start_evt (start_evt),
  .stop_evt  (stop_evt),
  .wr_en     (wr_en),
  .sda_oe    (sda_oe),
  .fsm_state (fsm_state)
);

// File: tb/i2c_regbank_slave_tb.sv
module i2c_regbank_slave_tb;

  localparam int HP = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic strap = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe;
  logic sda_bus;

  int checks = 0;
  int errors = 0;
  int oe_viol = 0;
  bit done = 1'b0;

  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic [7:0] obs_q[$];

  always #2.5 clk = ~clk;

  assign sda_bus = sda_m & ~sda_oe;

  i2c_regbank_slave u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .addr_strap (strap),
    .scl_i      (scl_m),
    .sda_i      (sda_bus),
    .sda_oe     (sda_oe)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  function automatic logic [6:0] dev(input logic s);
    return {6'b001101, s};
  endfunction

  task automatic hold(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; hold(HP);
    scl_m = 1'b1; hold(HP);
    sda_m = 1'b0; hold(HP);
    scl_m = 1'b0;
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; hold(HP);
    scl_m = 1'b1; hold(HP);
    sda_m = 1'b1; hold(HP);
  endtask

  task automatic clk_bit(input logic b, output logic r);
    sda_m = b; hold(HP);
    scl_m = 1'b1; hold(HP / 2);
    r = sda_bus; hold(HP / 2);
    scl_m = 1'b0;
  endtask

  task automatic wbyte(input logic [7:0] b, output logic ack);
    logic r;
    for (int i = 7; i >= 0; i--) clk_bit(b[i], r);
    clk_bit(1'b1, ack);
  endtask

  task automatic rbyte(input logic nak, output logic [7:0] b);
    logic r;
    for (int i = 7; i >= 0; i--) begin
      clk_bit(1'b1, r);
      b[i] = r;
    end
    clk_bit(nak, r);
  endtask

  task automatic write_word(input logic [6:0] ra, input logic [8:0] v, input string tag);
    logic a;
    bus_start();
    wbyte({dev(strap), 1'b0}, a); check({tag, " dev ack"}, a, 0);
    wbyte({ra, v[8]}, a);         check({tag, " reg ack"}, a, 0);
    wbyte(v[7:0], a);             check({tag, " data ack"}, a, 0);
    bus_stop();
  endtask

  // scoreboard driver: expected bytes queued, observed bytes pushed for the monitor
  task automatic read_reg(input logic [6:0] ra, input int pairs, input logic [8:0] v,
                          input string tag);
    logic a;
    logic [7:0] b;
    for (int p = 0; p < pairs; p++) begin
      exp_q.push_back({ra, v[8]}); tag_q.push_back({tag, " hi"});
      exp_q.push_back(v[7:0]);     tag_q.push_back({tag, " lo"});
    end
    bus_start();
    wbyte({dev(strap), 1'b0}, a); check({tag, " rd dev ack"}, a, 0);
    wbyte({ra, 1'b0}, a);         check({tag, " rd reg ack"}, a, 0);
    bus_start();
    wbyte({dev(strap), 1'b1}, a); check({tag, " rd devr ack"}, a, 0);
    for (int k = 0; k < 2 * pairs; k++) begin
      rbyte(k == 2 * pairs - 1, b);
      obs_q.push_back(b);
    end
    bus_stop();
  endtask

  initial begin : monitor
    logic [7:0] v;
    logic [7:0] e;
    string t;
    forever begin
      @(negedge clk);
      while (obs_q.size() > 0 && exp_q.size() > 0) begin
        v = obs_q.pop_front();
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        checks++;
        if (v !== e) begin
          errors++;
          $display("FAIL %s: got %0h expected %0h", t, v, e);
        end
      end
    end
  end

  // R8: the pull-down may only move while the master holds SCL low
  logic oe_prev = 1'b0;
  always @(negedge clk) begin
    if (rst_n && sda_oe !== oe_prev && scl_m) oe_viol++;
    oe_prev <= sda_oe;
  end

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    logic a;
    logic [7:0] b;
    hold(10);
    check("R9 oe in reset", sda_oe, 0);
    rst_n = 1'b1;
    hold(10);
    check("R9 oe after reset", sda_oe, 0);

    read_reg(7'd3, 1, 9'h000, "R9 reset value");

    write_word(7'd5, 9'h1A5, "R3 write");
    read_reg(7'd5, 1, 9'h1A5, "R3 R6 readback");

    write_word(7'd127, 9'h0FF, "R3 top reg");
    read_reg(7'd127, 1, 9'h0FF, "R6 top reg");

    // R2: wrong address, then bytes that would overwrite reg 5
    bus_start();
    wbyte({dev(1'b1), 1'b0}, a); check("R2 mismatch no ack", a, 1);
    wbyte({7'd5, 1'b0}, a);      check("R2 ignored reg byte", a, 1);
    wbyte(8'h00, a);             check("R2 ignored data byte", a, 1);
    bus_stop();
    read_reg(7'd5, 1, 9'h1A5, "R2 reg untouched");

    // R2: strap selects the other address
    strap = 1'b1;
    bus_start();
    wbyte({dev(1'b0), 1'b0}, a); check("R2 strap1 old addr nack", a, 1);
    bus_stop();
    write_word(7'd6, 9'h100, "R2 strap1 write");
    read_reg(7'd6, 1, 9'h100, "R2 strap1 readback");
    strap = 1'b0;

    // R4: STOP four bits into the data byte
    bus_start();
    wbyte({dev(strap), 1'b0}, a); check("R4 dev ack", a, 0);
    wbyte({7'd5, 1'b0}, a);       check("R4 reg ack", a, 0);
    for (int i = 0; i < 4; i++) clk_bit(1'b0, a);
    bus_stop();
    read_reg(7'd5, 1, 9'h1A5, "R4 stop discards");

    // R1 R4: repeated START right after the register byte
    bus_start();
    wbyte({dev(strap), 1'b0}, a); check("R1 dev ack", a, 0);
    wbyte({7'd5, 1'b1}, a);       check("R1 reg ack", a, 0);
    bus_start();
    wbyte({dev(strap), 1'b0}, a); check("R1 restart dev ack", a, 0);
    wbyte({7'd7, 1'b0}, a);       check("R1 restart reg ack", a, 0);
    wbyte(8'h55, a);              check("R1 restart data ack", a, 0);
    bus_stop();
    read_reg(7'd7, 1, 9'h055, "R1 restart write");
    read_reg(7'd5, 1, 9'h1A5, "R4 restart discards");

    // R5: extra byte after a full word
    bus_start();
    wbyte({dev(strap), 1'b0}, a); check("R5 dev ack", a, 0);
    wbyte({7'd8, 1'b1}, a);       check("R5 reg ack", a, 0);
    wbyte(8'hC3, a);              check("R5 data ack", a, 0);
    wbyte({7'd8, 1'b0}, a);       check("R5 extra byte nack", a, 1);
    wbyte(8'h00, a);              check("R5 extra byte2 nack", a, 1);
    bus_stop();
    read_reg(7'd8, 1, 9'h1C3, "R5 word intact");

    // R6: alternating bytes across several master acks
    read_reg(7'd5, 3, 9'h1A5, "R6 burst");

    // R7: after NACK the slave stays off the bus
    bus_start();
    wbyte({dev(strap), 1'b0}, a); check("R7 dev ack", a, 0);
    wbyte({7'd6, 1'b0}, a);       check("R7 reg ack", a, 0);
    bus_start();
    wbyte({dev(strap), 1'b1}, a); check("R7 devr ack", a, 0);
    rbyte(1'b1, b);               check("R7 first byte", b, 8'h0D);
    rbyte(1'b0, b);               check("R7 released after nack", b, 8'hFF);
    bus_stop();

    hold(50);
    check("R8 oe changes with SCL high", oe_viol, 0);
    check("scoreboard drained", exp_q.size(), 0);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule